// File: doc/BRIEF.md
# Eight-Level Priority Interrupt Controller

This block collects eight interrupt request lines and presents a single request to a CPU. A rising edge on a line marks that level pending. A fixed-priority resolver, with line 0 the most urgent and line 7 the least, picks one winner from the levels that are pending, not masked, and more urgent than every level already being serviced. The CPU request output stays high while such a winner exists.

The CPU answers with two active-low acknowledge pulses. The first pulse moves the winner from the pending set into the in-service set. During the second pulse the block drives an 8-bit vector onto the shared data port. The vector is the programmed 5-bit base followed by the 3-bit level number.

A small register port lets the CPU do four things: write and read the mask, load the vector base, choose which status register address 0 returns, and issue a non-specific end-of-interrupt. It uses chip select, read and write strobes, and one address bit. Cascading between controllers is not supported, and the three cascade outputs are tied low.

Top module: `prio_irq_ctrl`

## Requirements
- R1: After reset the pending, mask and in-service registers all read zero, the CPU request output is low, and the data port is high-impedance.
- R2: A rising edge on a request line sets that level's pending bit. The bit stays set after the line falls, and it is cleared only when that level is taken by an acknowledge.
- R3: Fixed priority applies among eligible levels: the lowest-numbered one wins.
- R4: A write at address 1 loads the mask, and a read at address 1 returns it. A masked level is never taken, while lower-priority unmasked levels can still win.
- R5: A level in service blocks pending levels of equal and lower priority. A more urgent unmasked pending level still raises the request.
- R6: The CPU request output is high exactly when at least one eligible level exists.
- R7: On the falling edge of the first acknowledge pulse, the winner's bit is set in the in-service register and cleared from the pending register.
- R8: While the second acknowledge pulse is low, the data port carries {base[4:0], level[2:0]}. The base is loaded by a write at address 0 with data bit 7 = 1, taking data bits 4:0.
- R9: A write at address 0 with bit 7 = 0 and bit 5 = 1 clears the lowest-numbered bit set in the in-service register.
- R10: A write at address 0 with bit 7 = 0 and bit 3 = 1 sets the read select to data bit 0. A read at address 0 then returns the pending register when the select is 0 and the in-service register when it is 1.
- R11: The data port is driven only during a selected read or the vector phase of the second acknowledge pulse.
- R12: If no eligible level exists at the first acknowledge pulse, the in-service register is unchanged and the vector carries level 7.
- R13: The three cascade outputs are always 000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_in | input | 8 | Request lines, bit 0 most urgent |
| cs_n | input | 1 | Register port select, active low |
| rd_n | input | 1 | Read strobe, active low |
| wr_n | input | 1 | Write strobe, active low (acts on its falling edge) |
| a0 | input | 1 | Register address bit |
| dbus | inout | 8 | Shared data port |
| ack_n | input | 1 | CPU acknowledge, active low |
| cpu_req | output | 1 | Interrupt request to the CPU |
| casc | output | 3 | Cascade code, fixed at 000 |

## Verification
The embedded assertions check, on every cycle, the following properties:
- Each cycle adds at most one in-service bit and removes at most one.
- A level that was masked is never moved into service.
- A pending bit disappears only when that level enters service.
- The request output is never high without a pending level.
- The request output is never high while level 0 is in service.

Some behaviours can only be shown by the bench's scenarios:
- the exact vector value, including the empty-acknowledge case;
- which of several pending levels wins;
- the effect of the read select;
- the request coming back after end-of-interrupt;
- the high-impedance data port.

// File: rtl/irqc_pkg.sv
package irqc_pkg;
    localparam int unsigned LINES  = 8;
    localparam int unsigned LVL_W  = $clog2(LINES);
    localparam int unsigned DW     = 8;
    localparam int unsigned BASE_W = DW - LVL_W;
    localparam int unsigned CASC_W = 3;

    typedef struct packed {
        logic [LINES-1:0]  pend;
        logic [LINES-1:0]  mask;
        logic [LINES-1:0]  isr;
        logic [LINES-1:0]  irq_prev;
        logic [BASE_W-1:0] base;
        logic              sel;
        logic              phase;
        logic              drv;
        logic [LVL_W-1:0]  lvl;
        logic              wr_prev;
        logic              ack_prev;
    } ctl_t;
endpackage

// File: rtl/irqc_prio_pick.sv
// Fixed-priority pick: lowest set index wins.
module irqc_prio_pick #(
    parameter int unsigned N = 8,
    localparam int unsigned W = $clog2(N)
) (
    input  logic [N-1:0] vec,
    output logic         hit,
    output logic [W-1:0] idx
);
    always_comb begin
        hit = 1'b0;
        idx = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (vec[i]) begin
                hit = 1'b1;
                idx = W'(i);
            end
        end
    end
endmodule

// File: rtl/irqc_gate.sv
// Eligibility: pending, unmasked, and above every in-service level.
module irqc_gate #(
    parameter int unsigned N = 8
) (
    input  logic [N-1:0] pend,
    input  logic [N-1:0] mask,
    input  logic [N-1:0] isr,
    output logic [N-1:0] elig
);
    genvar g;
    generate
        for (g = 0; g < N; g++) begin : g_lvl
            assign elig[g] = pend[g] & ~mask[g] & ~(|isr[g:0]);
        end
    endgenerate
endmodule

// File: rtl/prio_irq_ctrl.sv
module prio_irq_ctrl
    import irqc_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [LINES-1:0]  irq_in,
    input  logic              cs_n,
    input  logic              rd_n,
    input  logic              wr_n,
    input  logic              a0,
    inout  wire  [DW-1:0]     dbus,
    input  logic              ack_n,
    output logic              cpu_req,
    output logic [CASC_W-1:0] casc
);
    ctl_t q, d;

    logic [LINES-1:0] elig;
    logic             any_elig;
    logic [LVL_W-1:0] win;
    logic             isr_hit;
    logic [LVL_W-1:0] isr_top;
    logic             wr_fire, ack_fall, rd_on, drv_on, oe;
    logic [DW-1:0]    dout;

    irqc_gate #(.N(LINES)) i_gate (
        .pend(q.pend), .mask(q.mask), .isr(q.isr), .elig(elig)
    );

    irqc_prio_pick #(.N(LINES)) i_pick_req (
        .vec(elig), .hit(any_elig), .idx(win)
    );

    irqc_prio_pick #(.N(LINES)) i_pick_isr (
        .vec(q.isr), .hit(isr_hit), .idx(isr_top)
    );

    assign wr_fire  = ~wr_n & ~cs_n & q.wr_prev;
    assign ack_fall = ~ack_n & q.ack_prev;
    assign rd_on    = ~cs_n & ~rd_n;
    assign drv_on   = q.drv & ~ack_n;
    assign oe       = rd_on | drv_on;

    always_comb begin
        d          = q;
        d.irq_prev = irq_in;
        d.wr_prev  = wr_n | cs_n;
        d.ack_prev = ack_n;
        if (ack_n) d.drv = 1'b0;

        if (ack_fall) begin
            if (!q.phase) begin
                d.phase = 1'b1;
                if (any_elig) begin
                    d.isr[win]  = 1'b1;
                    d.pend[win] = 1'b0;
                    d.lvl       = win;
                end else begin
                    d.lvl = '1;
                end
            end else begin
                d.phase = 1'b0;
                d.drv   = 1'b1;
            end
        end

        if (wr_fire) begin
            if (a0) begin
                d.mask = dbus[LINES-1:0];
            end else if (dbus[7]) begin
                d.base = dbus[BASE_W-1:0];
            end else begin
                if (dbus[5] && isr_hit) d.isr[isr_top] = 1'b0;
                if (dbus[3]) d.sel = dbus[0];
            end
        end

        d.pend = d.pend | (irq_in & ~q.irq_prev);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q          <= '0;
            q.wr_prev  <= 1'b1;
            q.ack_prev <= 1'b1;
        end else begin
            q <= d;
        end
    end

    always_comb begin
        if (drv_on)      dout = {q.base, q.lvl};
        else if (a0)     dout = DW'(q.mask);
        else if (q.sel)  dout = DW'(q.isr);
        else             dout = DW'(q.pend);
    end

    assign dbus    = oe ? dout : 'z;
    assign cpu_req = any_elig;
    assign casc    = '0;

    // R7: one acknowledge adds at most one in-service level per cycle
    a_r7_one_new_isr: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(q.isr & ~$past(q.isr)) <= 1);

    // R9: one end-of-interrupt removes at most one level per cycle
    a_r9_one_eoi: assert property (@(posedge clk) disable iff (!rst_n)
        $countones($past(q.isr) & ~q.isr) <= 1);

    // R4: a level masked in the previous cycle never enters service
    a_r4_masked_never_serviced: assert property (@(posedge clk) disable iff (!rst_n)
        (q.isr & ~$past(q.isr) & $past(q.mask)) == '0);

    // R2: a pending bit clears only when its level enters service
    a_r2_pend_clears_on_ack: assert property (@(posedge clk) disable iff (!rst_n)
        (($past(q.pend) & ~q.pend) & ~(q.isr & ~$past(q.isr))) == '0);

    // R6: the request needs a pending level
    a_r6_req_has_pending: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_req |-> (|q.pend));

    // R5: the most urgent level in service blocks everything
    a_r5_top_level_blocks: assert property (@(posedge clk) disable iff (!rst_n)
        q.isr[0] |-> !cpu_req);
endmodule

// File: tb/test_prio_irq_ctrl.sv
module test_prio_irq_ctrl;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] irq_in = '0;
    logic       cs_n = 1'b1, rd_n = 1'b1, wr_n = 1'b1, a0 = 1'b0, ack_n = 1'b1;
    logic [7:0] tb_d = '0;
    logic       tb_oe = 1'b0;
    wire  [7:0] dbus;
    logic       cpu_req;
    logic [2:0] casc;

    assign dbus = tb_oe ? tb_d : 'z;

    always #10 clk = ~clk;

    prio_irq_ctrl i_prio_irq_ctrl (
        .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .cs_n(cs_n), .rd_n(rd_n),
        .wr_n(wr_n), .a0(a0), .dbus(dbus), .ack_n(ack_n), .cpu_req(cpu_req),
        .casc(casc)
    );

    typedef struct { logic [7:0] v; string tag; } exp_t;
    exp_t       exp_q[$];
    int         n_chk = 0, n_fail = 0;
    logic [7:0] obs;
    event       ev_obs;

    // Monitor: pops the expected item and compares it with the observation
    initial forever begin
        @(ev_obs);
        if (exp_q.size() == 0) begin
            n_chk++; n_fail++;
            $display("FAIL scoreboard empty actual=%h expected=none", obs);
        end else begin
            exp_t e;
            e = exp_q.pop_front();
            n_chk++;
            if (obs !== e.v) begin
                n_fail++;
                $display("FAIL %s actual=%h expected=%h", e.tag, obs, e.v);
            end
        end
    end

    task automatic push_exp(input logic [7:0] v, input string tag);
        exp_t e;
        e.v = v; e.tag = tag;
        exp_q.push_back(e);
    endtask

    task automatic observe(input logic [7:0] v);
        obs = v;
        -> ev_obs;
        #1;
    endtask

    task automatic wr(input logic a, input logic [7:0] v);
        @(negedge clk);
        cs_n = 1'b0; wr_n = 1'b0; a0 = a; tb_d = v; tb_oe = 1'b1;
        @(negedge clk);
        cs_n = 1'b1; wr_n = 1'b1; tb_oe = 1'b0;
    endtask

    task automatic rd(input logic a, input logic [7:0] ev, input string tag);
        push_exp(ev, tag);
        @(negedge clk);
        cs_n = 1'b0; rd_n = 1'b0; a0 = a;
        #5 observe(dbus);
        @(negedge clk);
        cs_n = 1'b1; rd_n = 1'b1;
    endtask

    task automatic chk_req(input logic ev, input string tag);
        push_exp({7'b0, ev}, tag);
        @(negedge clk);
        #5 observe({7'b0, cpu_req});
    endtask

    task automatic chk_hiz(input string tag);
        push_exp(8'hzz, tag);
        @(negedge clk);
        #5 observe(dbus);
    endtask

    task automatic pulse_irq(input logic [7:0] bits);
        @(negedge clk);
        irq_in = irq_in | bits;
        @(negedge clk);
        irq_in = irq_in & ~bits;
    endtask

    task automatic ack_first();
        @(negedge clk);
        ack_n = 1'b0;
        @(negedge clk);
        ack_n = 1'b1;
    endtask

    task automatic ack_second(input logic [7:0] ev, input string tag);
        @(negedge clk);
        ack_n = 1'b0;
        push_exp(ev, tag);
        @(negedge clk);
        #5 observe(dbus);
        ack_n = 1'b1;
    endtask

    initial begin
        #(20 * 100000);
        n_chk++; n_fail++;
        $display("FAIL watchdog actual=hung expected=finished");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        rd(1'b0, 8'h00, "R1 pending after reset");
        rd(1'b1, 8'h00, "R1 mask after reset");
        chk_req(1'b0, "R1 request low after reset");
        chk_hiz("R1 R11 port idle");
        push_exp(8'h00, "R13 cascade code");
        @(negedge clk);
        observe({5'b0, casc});

        wr(1'b0, 8'h8A);                         // base 01010 (R8)
        pulse_irq(8'h28);
        rd(1'b0, 8'h28, "R2 pending held after lines drop");
        chk_req(1'b1, "R6 request with eligible level");

        wr(1'b1, 8'h08);
        rd(1'b1, 8'h08, "R4 mask readback");
        ack_first();
        wr(1'b0, 8'h09);                         // select in-service (R10)
        rd(1'b0, 8'h20, "R4 R7 lower unmasked level taken");
        ack_second(8'h55, "R8 vector level 5");
        chk_hiz("R11 port released after vector");
        wr(1'b0, 8'h08);                         // select pending (R10)
        rd(1'b0, 8'h08, "R7 R10 taken level left pending");
        chk_req(1'b0, "R4 masked level raises nothing");

        wr(1'b1, 8'h00);
        chk_req(1'b1, "R5 more urgent level passes in-service");
        pulse_irq(8'h40);
        ack_first();
        ack_second(8'h53, "R5 vector level 3");
        chk_req(1'b0, "R5 level 6 blocked by service");
        wr(1'b0, 8'h09);
        rd(1'b0, 8'h28, "R7 R10 two levels in service");
        wr(1'b0, 8'h20);
        rd(1'b0, 8'h20, "R9 eoi clears most urgent");
        chk_req(1'b0, "R9 level 5 still blocks 6");
        wr(1'b0, 8'h20);
        chk_req(1'b1, "R9 request returns after eoi");
        ack_first();
        ack_second(8'h56, "R8 vector level 6");
        wr(1'b0, 8'h20);
        rd(1'b0, 8'h00, "R9 in-service empty");

        pulse_irq(8'h06);
        ack_first();
        ack_second(8'h51, "R3 level 1 beats level 2");
        rd(1'b0, 8'h02, "R3 only level 1 in service");
        wr(1'b0, 8'h20);
        ack_first();
        ack_second(8'h52, "R3 level 2 next");
        wr(1'b0, 8'h20);
        chk_req(1'b0, "R6 nothing pending");

        ack_first();
        ack_second(8'h57, "R12 empty acknowledge vector");
        rd(1'b0, 8'h00, "R12 in-service unchanged");
        chk_hiz("R11 port idle at end");

        repeat (2) @(negedge clk);
        if (exp_q.size() != 0) begin
            n_chk++; n_fail++;
            $display("FAIL scoreboard left=%0d expected=0", exp_q.size());
        end
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule